// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Array

This block multiplies a stream of signed 8-bit activation vectors by a square tile of signed 8-bit weights held inside an N x N grid of multiply-accumulate cells. Each cell keeps its weight still while activations pass through it from left to right and partial sums pass from top to bottom. A cell only ever reads values handed to it by its left and upper neighbours. Every result column leaves the bottom edge as a signed 32-bit sum that is ready for a downstream accumulator. The block skews the input rows so that each diagonal wavefront stays aligned. It then realigns the bottom columns so that each input vector yields one complete result vector on a single strobe.

Every cell has a shadow weight register next to its active one. The next tile shifts in from the top edge, one row per load cycle, while the current tile keeps computing. A block-start flag travels with the first vector of a new block. In each cell it reaches, the shadow weight is promoted to active at the moment that vector passes. The tile switch therefore sweeps diagonally across the grid with the data, and back-to-back blocks that use different tiles need no bubble between them.

Top module: `wsmac_array`

## Requirements
- R1: During and after reset, `out_valid` is low, `out_vec` is zero and every weight (active and shadow) is zero. Vectors sent before the first block start therefore produce all-zero results.
- R2: Each result satisfies y[j] = sum over i of w[i][j] * x[i], with signed two's-complement operands and a signed 32-bit result. Lane i of `act_vec` is bits [8i+7:8i], column j of `wt_row` is bits [8j+7:8j], and column j of `out_vec` is bits [32j+31:32j].
- R3: A vector sampled at clock edge k sets `out_valid` for exactly one cycle after edge k+2N-1. All N result columns appear together, results keep input order, and back-to-back inputs give back-to-back strobes.
- R4: Each cycle with `wt_load` high shifts the staged weights down one row and places `wt_row` in row 0. After N loads, the row presented at load number m (counting from 0) sits in array row N-1-m.
- R5: A valid vector with `act_start` high, and every later vector up to the next valid start, is computed with the tile staged at the time that start is sampled. Vectors before that start keep using the previous tile.
- R6: A load may run while a block is streaming. `wt_load` must be low in the cycle a valid start is sampled and in the 2N-3 cycles after it. Under that rule, loads have no effect on the results of vectors already sent.
- R7: Cycles with `act_valid` low produce no strobe and change no weight. In particular, `act_start` with `act_valid` low does not swap tiles.
- R8: `out_vec` changes only in a cycle where `out_valid` is high, and it holds the last result between strobes.
- R9: Full-scale operands (-128 x -128 on every lane, and mixed 127 / -128) produce the exact sums with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_load | input | 1 | Shift `wt_row` into the shadow weight chain this cycle |
| wt_row | input | 8*N | One weight row, column j in bits [8j+7:8j] |
| act_valid | input | 1 | `act_vec` carries a vector this cycle |
| act_start | input | 1 | This vector begins a new block (swap to staged tile) |
| act_vec | input | 8*N | Activation vector, lane i in bits [8i+7:8i] |
| out_valid | output | 1 | One-cycle strobe: `out_vec` holds a new result |
| out_vec | output | 32*N | Result vector, column j in bits [32j+31:32j] |

## Verification
Every result is due 2N-1 edges after its vector is sampled, which is 7 edges for the 4 x 4 bench instance. The input skew, the cell hops and the column realignment all add up to this same figure for every column. The bench records the edge count when it drives each vector and the edge count at which each strobe is observed, sampling both on the falling edge. It then requires the difference to equal the latency exactly, and it compares each result with a matrix product that it computes itself. A tile loaded in the middle of a block is placed at the earliest legal cycle, 2N-2 edges after the start. This exercises the tightest case of the diagonal swap.

// File: rtl/wsmac_pkg.sv
package wsmac_pkg;

    localparam int OPW  = 8;
    localparam int SUMW = 32;

    typedef logic signed [OPW-1:0]  opnd_t;
    typedef logic signed [SUMW-1:0] sum_t;

    typedef struct packed {
        opnd_t act;
        logic  vld;
        logic  blk;
        sum_t  psum;
        opnd_t shadow;
        opnd_t active;
    } cell_st_t;

    function automatic sum_t mac_step(sum_t acc, opnd_t w, opnd_t a);
        logic signed [2*OPW-1:0] prod;
        prod = w * a;
        return acc + sum_t'(prod);
    endfunction

endpackage

// File: rtl/wsmac_stagger.sv
module wsmac_stagger #(
    parameter int LANES   = 4,
    parameter int W       = 8,
    parameter int REVERSE = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0][W-1:0]   lane_in,
    output logic [LANES-1:0][W-1:0]   lane_out
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int DLY = (REVERSE != 0) ? (LANES - 1 - l) : l;

        if (DLY == 0) begin : g_thru
            assign lane_out[l] = lane_in[l];
        end else begin : g_pipe
            logic [DLY-1:0][W-1:0] pipe_d, pipe_q;

            always_comb begin
                pipe_d[0] = lane_in[l];
                for (int k = 1; k < DLY; k++) begin
                    pipe_d[k] = pipe_q[k-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign lane_out[l] = pipe_q[DLY-1];
        end
    end

endmodule

// File: rtl/wsmac_cell.sv
module wsmac_cell
    import wsmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wt_load,
    input  opnd_t sh_in,
    output opnd_t sh_out,
    input  opnd_t a_in,
    input  logic  v_in,
    input  logic  s_in,
    output opnd_t a_out,
    output logic  v_out,
    output logic  s_out,
    input  sum_t  p_in,
    output sum_t  p_out
);

    cell_st_t st_d, st_q;
    opnd_t    w_use;

    always_comb begin
        st_d  = st_q;
        w_use = st_q.active;
        if (v_in && s_in) begin
            w_use         = st_q.shadow;
            st_d.active   = st_q.shadow;
        end
        if (wt_load) begin
            st_d.shadow = sh_in;
        end
        st_d.act  = a_in;
        st_d.vld  = v_in;
        st_d.blk  = v_in && s_in;
        st_d.psum = v_in ? mac_step(p_in, w_use, a_in) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sh_out = st_q.shadow;
    assign a_out  = st_q.act;
    assign v_out  = st_q.vld;
    assign s_out  = st_q.blk;
    assign p_out  = st_q.psum;

endmodule

// File: rtl/wsmac_array.sv
module wsmac_array
    import wsmac_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_load,
    input  logic [N*8-1:0]    wt_row,
    input  logic              act_valid,
    input  logic              act_start,
    input  logic [N*8-1:0]    act_vec,
    output logic              out_valid,
    output logic [N*32-1:0]   out_vec
);

    localparam int SKW  = OPW + 2;
    localparam int DSKW = SUMW + 1;
    localparam int VECW = N * SUMW;

    // left-edge skew
    logic [N-1:0][SKW-1:0] skw_in, skw_out;

    for (genvar i = 0; i < N; i++) begin : g_skin
        assign skw_in[i] = {act_valid, act_start, act_vec[i*OPW +: OPW]};
    end

    wsmac_stagger #(.LANES(N), .W(SKW), .REVERSE(0)) u_skew (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_in  (skw_in),
        .lane_out (skw_out)
    );

    // grid links
    opnd_t a_h  [N][N];
    logic  v_h  [N][N];
    logic  s_h  [N][N];
    sum_t  p_v  [N][N];
    opnd_t sh_v [N][N];
    sum_t  bot_p [N];
    logic  bot_v [N];

    for (genvar i = 0; i < N; i++) begin : g_ledge
        assign a_h[i][0] = opnd_t'(skw_out[i][OPW-1:0]);
        assign s_h[i][0] = skw_out[i][OPW];
        assign v_h[i][0] = skw_out[i][OPW+1];
    end

    for (genvar j = 0; j < N; j++) begin : g_tedge
        assign p_v[0][j]  = '0;
        assign sh_v[0][j] = opnd_t'(wt_row[j*OPW +: OPW]);
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            opnd_t a_o, sh_o;
            logic  v_o, s_o;
            sum_t  p_o;

            wsmac_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .wt_load (wt_load),
                .sh_in   (sh_v[i][j]),
                .sh_out  (sh_o),
                .a_in    (a_h[i][j]),
                .v_in    (v_h[i][j]),
                .s_in    (s_h[i][j]),
                .a_out   (a_o),
                .v_out   (v_o),
                .s_out   (s_o),
                .p_in    (p_v[i][j]),
                .p_out   (p_o)
            );

            if (j < N-1) begin : g_right
                assign a_h[i][j+1] = a_o;
                assign v_h[i][j+1] = v_o;
                assign s_h[i][j+1] = s_o;
            end else begin : g_redge
                logic [OPW+1:0] redge_unused;
                assign redge_unused = {a_o, v_o, s_o};
            end

            if (i < N-1) begin : g_down
                assign p_v[i+1][j]  = p_o;
                assign sh_v[i+1][j] = sh_o;
            end else begin : g_bedge
                logic [OPW-1:0] bedge_unused;
                assign bedge_unused = sh_o;
                assign bot_p[j]     = p_o;
                assign bot_v[j]     = v_o;
            end
        end
    end

    // bottom-edge deskew
    logic [N-1:0][DSKW-1:0] dsk_in, dsk_out;
    logic [N-1:0]           dsk_vld;
    sum_t                   dsk_p [N];

    for (genvar j = 0; j < N; j++) begin : g_dsk
        assign dsk_in[j]  = {bot_v[j], bot_p[j]};
        assign dsk_vld[j] = dsk_out[j][SUMW];
        assign dsk_p[j]   = sum_t'(dsk_out[j][SUMW-1:0]);
    end

    wsmac_stagger #(.LANES(N), .W(DSKW), .REVERSE(1)) u_deskew (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_in  (dsk_in),
        .lane_out (dsk_out)
    );

    // result register
    logic            out_vld_d, out_vld_q;
    logic [VECW-1:0] out_vec_d, out_vec_q;

    always_comb begin
        out_vld_d = dsk_vld[0];
        out_vec_d = out_vec_q;
        if (dsk_vld[0]) begin
            for (int j = 0; j < N; j++) begin
                out_vec_d[j*SUMW +: SUMW] = dsk_p[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_q <= 1'b0;
            out_vec_q <= '0;
        end else begin
            out_vld_q <= out_vld_d;
            out_vec_q <= out_vec_d;
        end
    end

    assign out_valid = out_vld_q;
    assign out_vec   = out_vec_q;

endmodule

// File: rtl/wsmac_array_chk.sv
module wsmac_array_chk #(
    parameter int N = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wt_load,
    input logic            act_valid,
    input logic            act_start,
    input logic            out_valid,
    input logic [N*32-1:0] out_vec,
    input logic [N-1:0]    col_vld
);

    localparam int LAT = 2*N - 1;
    localparam int GW  = $clog2(2*N) + 1;

    logic [LAT:0]  hist_q;
    logic [GW-1:0] guard_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= '0;
            guard_q <= '0;
        end else begin
            hist_q <= {hist_q[LAT-1:0], act_valid};
            if (act_valid && act_start) begin
                guard_q <= GW'(2*N - 3);
            end else if (guard_q != '0) begin
                guard_q <= guard_q - 1'b1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_vec == '0));                         // R1
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hist_q[LAT]);                                               // R3
    AST_COL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld == '0) || (col_vld == '1));                                     // R3
    AST_START_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_start) |-> !wt_load);                                  // R6
    AST_LOAD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_q != '0) |-> !wt_load);                                           // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_vec) |-> out_valid);                                        // R8

endmodule

bind wsmac_array wsmac_array_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wt_load   (wt_load),
    .act_valid (act_valid),
    .act_start (act_start),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .col_vld   (dsk_vld)
);

// File: tb/wsmac_array_bench.sv
module wsmac_array_bench;

    localparam int N   = 4;
    localparam int LAT = 2*N - 1;
    localparam int SW  = 32;
    localparam int MAXQ = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wt_load = 1'b0;
    logic [N*8-1:0]    wt_row = '0;
    logic              act_valid = 1'b0;
    logic              act_start = 1'b0;
    logic [N*8-1:0]    act_vec = '0;
    logic              out_valid;
    logic [N*SW-1:0]   out_vec;

    always #2 clk = ~clk;

    wsmac_array #(.N(N)) u_wsmac_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wt_load   (wt_load),
        .wt_row    (wt_row),
        .act_valid (act_valid),
        .act_start (act_start),
        .act_vec   (act_vec),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    int sh_m  [N][N];
    int cur_m [N][N];

    logic [N*SW-1:0] exp_y [MAXQ];
    int              exp_c [MAXQ];
    int              exp_n = 0;
    logic [N*SW-1:0] rx_y  [MAXQ];
    int              rx_c  [MAXQ];
    int              rx_n  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [N*SW-1:0] act, input logic [N*SW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && rx_n < MAXQ) begin
            rx_y[rx_n] = out_vec;
            rx_c[rx_n] = cyc;
            rx_n++;
        end
    end

    // one cycle of stimulus, driven at the falling edge
    task automatic step(input bit v, input bit s, input logic [N*8-1:0] x,
                        input bit ld, input logic [N*8-1:0] row);
        act_valid = v;
        act_start = s;
        act_vec   = x;
        wt_load   = ld;
        wt_row    = row;
        if (v) begin
            if (s) cur_m = sh_m;
            for (int j = 0; j < N; j++) begin
                int acc = 0;
                for (int i = 0; i < N; i++) begin
                    acc += cur_m[i][j] * int'($signed(x[i*8 +: 8]));
                end
                exp_y[exp_n][j*SW +: SW] = acc;
            end
            exp_c[exp_n] = cyc + 1 + LAT;
            exp_n++;
        end
        if (ld) begin
            for (int r = N-1; r > 0; r--) sh_m[r] = sh_m[r-1];
            for (int j = 0; j < N; j++) sh_m[0][j] = int'($signed(row[j*8 +: 8]));
        end
        @(posedge clk);
        @(negedge clk);
        act_valid = 1'b0;
        act_start = 1'b0;
        wt_load   = 1'b0;
    endtask

    function automatic logic [N*8-1:0] tile_row(input int seed, input int r);
        logic [N*8-1:0] row;
        for (int j = 0; j < N; j++) row[j*8 +: 8] = 8'((seed*53 + r*29 + j*17 + r*j*7) % 256);
        return row;
    endfunction

    function automatic logic [N*8-1:0] vec_of(input int seed);
        logic [N*8-1:0] x;
        for (int i = 0; i < N; i++) x[i*8 +: 8] = 8'((seed*41 + i*23 + seed*i*3) % 256);
        return x;
    endfunction

    function automatic logic [N*8-1:0] fill(input logic [7:0] b);
        logic [N*8-1:0] x;
        for (int i = 0; i < N; i++) x[i*8 +: 8] = b;
        return x;
    endfunction

    // R4: rows go in bottom row first
    task automatic load_tile(input int seed);
        for (int r = N-1; r >= 0; r--) step(1'b0, 1'b0, '0, 1'b1, tile_row(seed, r));
    endtask

    task automatic finish_scn(input string req);
        repeat (2*N + 2) step(1'b0, 1'b0, '0, 1'b0, '0);
        check(rx_n == exp_n, "R3", "result count", N*SW'(rx_n), N*SW'(exp_n));
        for (int k = 0; k < exp_n && k < rx_n; k++) begin
            check(rx_y[k] == exp_y[k], req, "result vector", rx_y[k], exp_y[k]);
            check(rx_c[k] == exp_c[k], "R3", "strobe cycle", N*SW'(rx_c[k]), N*SW'(exp_c[k]));
        end
        exp_n = 0;
        rx_n  = 0;
    endtask

    task automatic t_reset;
        check(out_valid == 1'b0, "R1", "out_valid after reset", N*SW'(out_valid), '0);
        check(out_vec == '0, "R1", "out_vec after reset", out_vec, '0);
        step(1'b1, 1'b0, vec_of(3), 1'b0, '0);
        step(1'b1, 1'b0, fill(8'h7f), 1'b0, '0);
        finish_scn("R1");
    endtask

    task automatic t_single;
        load_tile(1);
        step(1'b1, 1'b1, vec_of(1), 1'b0, '0);
        step(1'b1, 1'b0, vec_of(2), 1'b0, '0);
        step(1'b1, 1'b0, 32'h0000_0001, 1'b0, '0);
        step(1'b1, 1'b0, 32'h0100_0000, 1'b0, '0);
        step(1'b1, 1'b0, fill(8'hff), 1'b0, '0);
        finish_scn("R2 R4");
    endtask

    task automatic t_back2back;
        load_tile(2);
        for (int t = 0; t < 3*N; t++) begin
            bit ld = (t >= 2*N-2) && (t < 3*N-2);
            step(1'b1, t == 0, vec_of(10 + t), ld, ld ? tile_row(3, 3*N-3-t) : '0);
        end
        for (int t = 0; t < N+2; t++) step(1'b1, t == 0, vec_of(30 + t), 1'b0, '0);
        finish_scn("R5 R6");
    endtask

    task automatic t_gaps;
        logic [N*SW-1:0] last;
        load_tile(4);
        step(1'b0, 1'b1, vec_of(5), 1'b0, '0);
        step(1'b1, 1'b0, vec_of(6), 1'b0, '0);
        step(1'b0, 1'b0, vec_of(7), 1'b0, '0);
        step(1'b0, 1'b1, vec_of(8), 1'b0, '0);
        step(1'b1, 1'b0, vec_of(9), 1'b0, '0);
        last = exp_y[exp_n-1];
        finish_scn("R7");
        check(out_vec == last, "R8", "hold between strobes", out_vec, last);
        step(1'b1, 1'b1, vec_of(6), 1'b0, '0);
        step(1'b0, 1'b0, '0, 1'b0, '0);
        step(1'b1, 1'b0, vec_of(9), 1'b0, '0);
        finish_scn("R5");
    endtask

    task automatic t_extreme;
        for (int r = 0; r < N; r++) step(1'b0, 1'b0, '0, 1'b1, fill(8'h80));
        step(1'b1, 1'b1, fill(8'h80), 1'b0, '0);
        step(1'b1, 1'b0, fill(8'h7f), 1'b0, '0);
        finish_scn("R9");
        for (int r = 0; r < N; r++) step(1'b0, 1'b0, '0, 1'b1, {8'h7f, 8'h80, 8'h7f, 8'h80});
        step(1'b1, 1'b1, fill(8'h80), 1'b0, '0);
        step(1'b1, 1'b0, {8'h80, 8'h7f, 8'h80, 8'h7f}, 1'b0, '0);
        finish_scn("R9");
    endtask

    initial begin
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin
            sh_m[i][j]  = 0;
            cur_m[i][j] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_single;
        t_back2back;
        t_gaps;
        t_extreme;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule